// File: doc/BRIEF.md
# Trace Capture Qualifier and Address Demultiplexer

This block sits between a sampled parallel bus and a trace store. On every clock it decides whether the bus sample should be written to the store, and it raises a store strobe for samples that pass. Two qualifier options can drop samples. One drops clocks classified as wait states, whether the wait comes from the master, from the target, or from a missing device-select response. The other drops clocks classified as idle. With both options off, every clock is stored.

The block also demultiplexes the address. Address words are collected while the address-valid cycle flag is high. When that flag falls, the collected address is transferred to a held-address output. It stays there for the rest of the transaction, so a trigger or filter can compare against it on data clocks. When the address phase takes two clocks, the held address is 64 bits wide: the first word forms the lower half and the second word forms the upper half.

The active-low grant line for the slot is latched when a transaction starts and is held until the next transaction starts. This lets the held grant act as a store qualifier. In timing mode all of this is bypassed: every clock is stored, and the sample word and grant pass through unlatched.

Top module: `trace_qual_demux`

## Requirements
- R1: Reset state. While reset is asserted and after it is released, with no clock having sampled activity yet and state mode selected, the outputs are: storeStb = 0, sampleWord = 0, heldAddr = 0, heldGntN = 1.
- R2: State mode with both options off. One clock after each rising edge, storeStb is 1, and sampleWord equals the ad value sampled at that edge.
- R3: State mode with noWaitEn = 1. Suppose a rising edge samples any of fMstWait, fTgtWait or fNoDevWait as 1. Then storeStb is 0 in the following cycle. Samples without those flags and without a suppressed idle flag still give storeStb = 1.
- R4: State mode with noIdleEn = 1. A rising edge that samples fIdle = 1 gives storeStb = 0 in the following cycle.
- R5: Single address clock. Consider a transaction whose fAddrValid is high for one clock carrying word A. From the first rising edge that samples fAddrValid low again, heldAddr = {AD_W zeros, A}.
- R6: Dual address clock. Consider a transaction whose fAddrValid is high for two clocks, carrying L and then H. From the edge that samples fAddrValid low, heldAddr = {H, L}. Address-valid clocks beyond the second are ignored.
- R7: heldAddr changes only at the rising edge that samples fAddrValid low after it was sampled high in state mode. This includes the address clocks of the next transaction, during which the previous value stays visible.
- R8: In state mode, heldGntN takes the gntN value sampled at the rising edge where fAddrValid is first seen high. It keeps that value on every later clock until the next such edge.
- R9: In timing mode (stateMode = 0), storeStb = 1 regardless of options and flags. sampleWord equals ad, and heldGntN equals gntN, both combinationally.
- R10: Address-valid activity during timing mode changes neither heldAddr nor the latched grant. On return to state mode, heldGntN shows the grant latched before timing mode was entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stateMode | input | 1 | 1 = state mode (qualified, latched); 0 = timing mode (bypass) |
| noWaitEn | input | 1 | Drop clocks flagged as any kind of wait |
| noIdleEn | input | 1 | Drop clocks flagged as idle |
| fMstWait | input | 1 | Cycle flag: master-inserted wait |
| fTgtWait | input | 1 | Cycle flag: target-inserted wait |
| fNoDevWait | input | 1 | Cycle flag: wait with no device-select response |
| fIdle | input | 1 | Cycle flag: bus idle |
| fAddrValid | input | 1 | Cycle flag: address on the bus this clock |
| gntN | input | 1 | Active-low grant line for the slot |
| ad | input | AD_W | Multiplexed address/data bus |
| storeStb | output | 1 | Store-enable strobe for the trace store |
| heldAddr | output | 2*AD_W | Address held through the transaction |
| heldGntN | output | 1 | Grant held through the transaction (raw in timing mode) |
| sampleWord | output | AD_W | Bus sample aligned with storeStb |

## Verification
In state mode, storeStb and sampleWord are due one clock after the edge that samples their inputs. heldAddr is due one clock after the edge that sees fAddrValid low following a high. heldGntN is due one clock after the edge that first sees fAddrValid high. In timing mode, storeStb, sampleWord and heldGntN follow their inputs within the same cycle. The bench applies inputs on the falling edge and lets the next rising edge update its behavioural model. It then compares every output at the following falling edge. So registered results are checked exactly one edge after their stimulus, and bypassed results are checked against the inputs still being driven.

// File: rtl/trace_qual_pkg.sv
package trace_qual_pkg;

  // Strobes from the control half to the datapath half, one set per clock.
  typedef struct packed {
    logic keepStore;   // this sample survives the qualifier options
    logic capLo;       // first address clock: capture lower word, latch grant
    logic capHi;       // second address clock: capture upper word
    logic commit;      // trailing edge of address-valid: publish address
    logic commitWide;  // publish both words (dual address clock)
  } ctrlStb_t;

endpackage

// File: rtl/trace_qual_ctrl.sv
module trace_qual_ctrl
  import trace_qual_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     stateMode,
  input  logic     noWaitEn,
  input  logic     noIdleEn,
  input  logic     fMstWait,
  input  logic     fTgtWait,
  input  logic     fNoDevWait,
  input  logic     fIdle,
  input  logic     fAddrValid,
  output ctrlStb_t stb
);

  logic avPrev;   // address-valid seen at previous edge (state mode only)
  logic hiTaken;  // upper word already collected for this address phase
  logic anyWait;
  logic dropWait;
  logic dropIdle;

  assign anyWait  = fMstWait | fTgtWait | fNoDevWait;
  assign dropWait = noWaitEn & anyWait;
  assign dropIdle = noIdleEn & fIdle;

  always_comb begin
    stb            = '0;
    stb.keepStore  = ~(dropWait | dropIdle);
    stb.capLo      = stateMode & fAddrValid & ~avPrev;
    stb.capHi      = stateMode & fAddrValid & avPrev & ~hiTaken;
    stb.commit     = stateMode & ~fAddrValid & avPrev;
    stb.commitWide = hiTaken;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      avPrev  <= 1'b0;
      hiTaken <= 1'b0;
    end else begin
      avPrev <= stateMode & fAddrValid;
      if (stb.capLo) begin
        hiTaken <= 1'b0;
      end else if (stb.capHi) begin
        hiTaken <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/trace_qual_data.sv
module trace_qual_data
  import trace_qual_pkg::*;
#(
  parameter int AD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stateMode,
  input  ctrlStb_t          stb,
  input  logic [AD_W-1:0]   ad,
  input  logic              gntN,
  output logic              storeStb,
  output logic [2*AD_W-1:0] heldAddr,
  output logic              heldGntN,
  output logic [AD_W-1:0]   sampleWord
);

  localparam int HA_W = 2 * AD_W;

  logic            storeQ;
  logic [AD_W-1:0] sampleQ;
  logic [AD_W-1:0] loWord;
  logic [AD_W-1:0] hiWord;
  logic [HA_W-1:0] addrQ;
  logic            gntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      storeQ  <= 1'b0;
      sampleQ <= '0;
    end else begin
      storeQ  <= stb.keepStore;
      sampleQ <= ad;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loWord <= '0;
      hiWord <= '0;
      gntQ   <= 1'b1;
    end else begin
      if (stb.capLo) begin
        loWord <= ad;
        gntQ   <= gntN;
      end
      if (stb.capHi) begin
        hiWord <= ad;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
    end else if (stb.commit) begin
      addrQ <= stb.commitWide ? {hiWord, loWord} : {{AD_W{1'b0}}, loWord};
    end
  end

  assign storeStb   = stateMode ? storeQ  : 1'b1;
  assign sampleWord = stateMode ? sampleQ : ad;
  assign heldGntN   = stateMode ? gntQ    : gntN;
  assign heldAddr   = addrQ;

endmodule

// File: rtl/trace_qual_demux.sv
module trace_qual_demux
  import trace_qual_pkg::*;
#(
  parameter int AD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stateMode,
  input  logic              noWaitEn,
  input  logic              noIdleEn,
  input  logic              fMstWait,
  input  logic              fTgtWait,
  input  logic              fNoDevWait,
  input  logic              fIdle,
  input  logic              fAddrValid,
  input  logic              gntN,
  input  logic [AD_W-1:0]   ad,
  output logic              storeStb,
  output logic [2*AD_W-1:0] heldAddr,
  output logic              heldGntN,
  output logic [AD_W-1:0]   sampleWord
);

  ctrlStb_t stb;

  trace_qual_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .stateMode  (stateMode),
    .noWaitEn   (noWaitEn),
    .noIdleEn   (noIdleEn),
    .fMstWait   (fMstWait),
    .fTgtWait   (fTgtWait),
    .fNoDevWait (fNoDevWait),
    .fIdle      (fIdle),
    .fAddrValid (fAddrValid),
    .stb        (stb)
  );

  trace_qual_data #(.AD_W(AD_W)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .stateMode  (stateMode),
    .stb        (stb),
    .ad         (ad),
    .gntN       (gntN),
    .storeStb   (storeStb),
    .heldAddr   (heldAddr),
    .heldGntN   (heldGntN),
    .sampleWord (sampleWord)
  );

endmodule

// File: rtl/trace_qual_demux_chk.sv
module trace_qual_demux_chk #(
  parameter int AD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              stateMode,
  input logic              noWaitEn,
  input logic              noIdleEn,
  input logic              fMstWait,
  input logic              fTgtWait,
  input logic              fNoDevWait,
  input logic              fIdle,
  input logic              fAddrValid,
  input logic              storeStb,
  input logic [2*AD_W-1:0] heldAddr,
  input logic              heldGntN
);

  logic prevAv;  // checker's own record of address-valid in state mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevAv <= 1'b0;
    else       prevAv <= stateMode & fAddrValid;
  end

  // R2: no options, state mode -> next sample stored
  p_all_store_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stateMode && !noWaitEn && !noIdleEn) ##1 stateMode |-> storeStb);

  // R3: wait clocks dropped
  p_drop_wait_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stateMode && noWaitEn && (fMstWait || fTgtWait || fNoDevWait)) ##1 stateMode
      |-> !storeStb);

  // R4: idle clocks dropped
  p_drop_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stateMode && noIdleEn && fIdle) ##1 stateMode |-> !storeStb);

  // R7 / R10: address changes only at the trailing edge in state mode
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(stateMode && !fAddrValid && prevAv) |=> $stable(heldAddr));

  // R8: grant held between transaction starts
  p_gnt_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stateMode && !(fAddrValid && !prevAv)) ##1 stateMode |-> $stable(heldGntN));

  // R9: timing mode stores every clock
  p_timing_store_r9: assert property (@(posedge clk) disable iff (!rstN)
    !stateMode |-> storeStb);

endmodule

bind trace_qual_demux trace_qual_demux_chk #(.AD_W(AD_W)) u_chk (.*);

// File: tb/test_trace_qual_demux.sv
module test_trace_qual_demux;

  localparam int AD_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              stateMode = 1'b1;
  logic              noWaitEn = 1'b0;
  logic              noIdleEn = 1'b0;
  logic              fMstWait = 1'b0;
  logic              fTgtWait = 1'b0;
  logic              fNoDevWait = 1'b0;
  logic              fIdle = 1'b0;
  logic              fAddrValid = 1'b0;
  logic              gntN = 1'b1;
  logic [AD_W-1:0]   ad = '0;
  logic              storeStb;
  logic [2*AD_W-1:0] heldAddr;
  logic              heldGntN;
  logic [AD_W-1:0]   sampleWord;

  int errors = 0;
  int checks = 0;
  string curReq = "R1";

  always #5 clk = ~clk;

  trace_qual_demux #(.AD_W(AD_W)) i_trace_qual_demux (.*);

  // Behavioural reference model
  logic              mStore;
  logic [AD_W-1:0]   mSample;
  logic [AD_W-1:0]   mLo, mHi;
  int                mCnt;
  logic              mPrev;
  logic [2*AD_W-1:0] mAddr;
  logic              mGnt;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mStore = 0; mSample = 0; mLo = 0; mHi = 0; mCnt = 0;
      mPrev = 0; mAddr = 0; mGnt = 1;
    end else begin
      mStore  = !(noWaitEn && (fMstWait || fTgtWait || fNoDevWait)) && !(noIdleEn && fIdle);
      mSample = ad;
      if (stateMode) begin
        if (fAddrValid) begin
          if (!mPrev) begin mLo = ad; mCnt = 1; mGnt = gntN; end
          else if (mCnt == 1) begin mHi = ad; mCnt = 2; end
        end else if (mPrev) begin
          mAddr = (mCnt == 2) ? {mHi, mLo} : {{AD_W{1'b0}}, mLo};
        end
        mPrev = fAddrValid;
      end else begin
        mPrev = 0;
      end
    end
  end

  task automatic chk1(string req, string what, logic [2*AD_W-1:0] act, logic [2*AD_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compareAll();
    chk1(curReq, "storeStb",   storeStb,   stateMode ? mStore : 1'b1);
    chk1(curReq, "sampleWord", sampleWord, stateMode ? mSample : ad);
    chk1(curReq, "heldGntN",   heldGntN,   stateMode ? mGnt : gntN);
    chk1(curReq, "heldAddr",   heldAddr,   mAddr);
  endtask

  task automatic tick(logic sm, logic av, logic g, logic [AD_W-1:0] d,
                      logic mw, logic tw, logic nd, logic idl);
    stateMode = sm; fAddrValid = av; gntN = g; ad = d;
    fMstWait = mw; fTgtWait = tw; fNoDevWait = nd; fIdle = idl;
    @(negedge clk);
    compareAll();
  endtask

  task automatic randomRun(int n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      tick(1'b1, r[0] & r[1], r[2], $urandom, r[3], r[4] & r[5], r[6] & r[7], r[5]);
    end
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1: reset values
    chk1("R1", "storeStb",   storeStb,   1'b0);
    chk1("R1", "sampleWord", sampleWord, '0);
    chk1("R1", "heldAddr",   heldAddr,   '0);
    chk1("R1", "heldGntN",   heldGntN,   1'b1);
    rstN = 1'b1;
    @(negedge clk);
    chk1("R1", "heldAddr after release", heldAddr, '0);

    curReq = "R2"; noWaitEn = 0; noIdleEn = 0; randomRun(60);
    tick(1, 0, 1, 32'hA5A5_0001, 1, 1, 1, 1);
    chk1("R2", "storeStb all flags", storeStb, 1'b1);
    chk1("R2", "sampleWord", sampleWord, 32'hA5A5_0001);

    curReq = "R3"; noWaitEn = 1; noIdleEn = 0; randomRun(60);
    tick(1, 0, 1, 32'h1, 0, 1, 0, 0);
    chk1("R3", "target wait dropped", storeStb, 1'b0);
    tick(1, 0, 1, 32'h2, 0, 0, 1, 0);
    chk1("R3", "no-devsel wait dropped", storeStb, 1'b0);
    tick(1, 0, 1, 32'h3, 0, 0, 0, 1);
    chk1("R3", "idle kept without noIdle", storeStb, 1'b1);

    curReq = "R4"; noWaitEn = 0; noIdleEn = 1; randomRun(60);
    tick(1, 0, 1, 32'h4, 0, 0, 0, 1);
    chk1("R4", "idle dropped", storeStb, 1'b0);
    tick(1, 0, 1, 32'h5, 1, 0, 0, 0);
    chk1("R4", "wait kept without noWait", storeStb, 1'b1);

    curReq = "R3 R4"; noWaitEn = 1; noIdleEn = 1; randomRun(60);

    // R5: single address clock
    curReq = "R5"; noWaitEn = 0; noIdleEn = 0;
    tick(1, 0, 1, 32'h0, 0, 0, 0, 0);
    tick(1, 1, 0, 32'h1000_0040, 0, 0, 0, 0);
    tick(1, 0, 1, 32'hDEAD_0001, 0, 0, 0, 0);
    chk1("R5", "single address", heldAddr, {32'h0, 32'h1000_0040});
    chk1("R8", "grant latched low", heldGntN, 1'b0);
    curReq = "R8";
    tick(1, 0, 1, 32'hDEAD_0002, 0, 0, 0, 0);
    tick(1, 0, 1, 32'hDEAD_0003, 0, 0, 0, 0);
    chk1("R8", "grant held", heldGntN, 1'b0);

    // R6: dual address clock (third valid clock ignored)
    curReq = "R6";
    tick(1, 1, 1, 32'h8765_4320, 0, 0, 0, 0);
    tick(1, 1, 0, 32'h0000_00FE, 0, 0, 0, 0);
    tick(1, 1, 0, 32'h5555_5555, 0, 0, 0, 0);
    tick(1, 0, 0, 32'hBEEF_0000, 0, 0, 0, 0);
    chk1("R6", "dual address", heldAddr, {32'h0000_00FE, 32'h8765_4320});
    chk1("R8", "grant from first address clock", heldGntN, 1'b1);

    // R7: held through data and next address clock
    curReq = "R7";
    tick(1, 0, 0, 32'h1111_1111, 0, 0, 0, 0);
    tick(1, 1, 1, 32'h2222_2220, 0, 0, 0, 0);
    chk1("R7", "held during next address", heldAddr, {32'h0000_00FE, 32'h8765_4320});
    tick(1, 0, 0, 32'h3333_3333, 0, 0, 0, 0);
    chk1("R7", "updated at trailing edge", heldAddr, {32'h0, 32'h2222_2220});

    // R9: timing mode bypass
    curReq = "R9"; noWaitEn = 1; noIdleEn = 1;
    tick(0, 0, 0, 32'hCAFE_0001, 1, 1, 1, 1);
    chk1("R9", "storeStb", storeStb, 1'b1);
    chk1("R9", "sampleWord raw", sampleWord, 32'hCAFE_0001);
    chk1("R9", "grant raw low", heldGntN, 1'b0);
    tick(0, 0, 1, 32'hCAFE_0002, 0, 0, 0, 1);
    chk1("R9", "grant raw high", heldGntN, 1'b1);

    // R10: no capture in timing mode
    curReq = "R10";
    tick(0, 1, 0, 32'h9999_0000, 0, 0, 0, 0);
    tick(0, 0, 0, 32'h9999_0001, 0, 0, 0, 0);
    chk1("R10", "address unchanged", heldAddr, {32'h0, 32'h2222_2220});
    tick(1, 0, 0, 32'h9999_0002, 0, 0, 0, 0);
    chk1("R10", "latched grant kept", heldGntN, 1'b1);
    chk1("R10", "address after return", heldAddr, {32'h0, 32'h2222_2220});

    curReq = "R2 R5"; noWaitEn = 0; noIdleEn = 0; randomRun(40);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule